// File: doc/BRIEF.md
# Switch-Selected Baud Clock Divider

This block turns one fast base-rate enable into the oversampling enable of a serial port. The base enable, nominally 153.6 kHz (128 times a 1200 Hz reference), feeds a chain of seven divide-by-two stages. An odd divide-by-eleven branch hangs off the third stage. A three-bit rate selector picks one of eight candidate sources. A strap input decides whether the top selector position takes the undivided base rate or half of it.

The chosen source becomes a single 16x oversampling enable, and receive and transmit both use it, so the two directions always run at the same rate. Every 16th oversampling pulse also raises a bit-rate enable. The last binary stage is brought out as the 1200 Hz comparison tick for the loop that produces the base rate. All logic runs in one system-clock domain, and every output is a one-cycle enable pulse, never a derived clock.

A change of selector or strap is held off until the newly requested source produces a pulse. That pulse only marks the switch-over and is not passed on. Output pulses therefore never come closer together than the period of the source in effect.

Top module: `baud_clock_divider`

## Requirements
- R1: A synchronous reset (`rst` high) clears every divide stage, the divide-by-eleven counter and the oversample counter, and drives all three outputs low. The source requested during reset becomes the active source.
- R2: `ref_tick` pulses once every 128 base ticks. The first pulse follows the 128th base tick after reset.
- R3: For selector values 0, 2, 3, 4, 5 and 6, `os_tick` pulses once every 128, 64, 32, 16, 8 and 4 base ticks respectively. The first pulse comes at the first whole multiple of that count since reset.
- R4: Selector value 1 divides the third-stage output (every 8 base ticks) by 11, so `os_tick` pulses once every 88 base ticks.
- R5: Selector value 7 gives one `os_tick` for every base tick when `half_top` is 0, and one for every second base tick when `half_top` is 1.
- R6: While the selector is not 7, `half_top` has no effect on any output.
- R7: After the requested source (selector together with strap) changes, `os_tick` stays low until the new source first pulses. That pulse makes the new source active and is itself suppressed. Pulses of the new source follow from then on. Two `os_tick` pulses are never fewer base ticks apart than the period of the active source.
- R8: `bit_tick` pulses together with every 16th `os_tick`, counted from reset, and never without `os_tick`.
- R9: Every output pulse appears in the cycle right after the clock edge that sampled the base tick causing it, and lasts one cycle.
- R10: While `base_tick` is low, no divide state advances and all outputs stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| base_tick | input | 1 | One-cycle base-rate enable (nominal 153.6 kHz) |
| rate_sel | input | 3 | Rate selector position, 0 to 7 |
| half_top | input | 1 | Strap: selector position 7 uses half the base rate when 1 |
| os_tick | output | 1 | 16x oversampling enable, shared by receive and transmit |
| bit_tick | output | 1 | Bit-rate enable, every 16th `os_tick` |
| ref_tick | output | 1 | Comparison tick at 1/128 of the base rate |

## Verification
The bench builds the block with its default parameters: seven binary stages, the odd branch tapped at stage three, divide by eleven and 16x oversampling. These values put the slowest period at 128 base ticks and the bit period at 2048 base ticks, so every source, the odd branch and several complete bit periods all fit inside a short run. Random segments with sparse and dense base ticks exercise switching between any pair of sources and strap toggles at every selector value.

// File: rtl/baud_pkg.sv
package baud_pkg;

  // Source numbering: 0..6 follow the selector, 7 = base rate, 8 = half base rate
  localparam int unsigned NUM_SRC = 9;
  localparam int unsigned SEL_W   = 3;

  typedef logic [3:0] src_id_t;

  localparam src_id_t SRC_BASE = 4'd7;
  localparam src_id_t SRC_HALF = 4'd8;

  // Map selector position and strap onto a source number
  function automatic src_id_t req_src(input logic [SEL_W-1:0] pos, input logic strap);
    if (pos == 3'd7) return strap ? SRC_HALF : SRC_BASE;
    return src_id_t'(pos);
  endfunction

  // Period of a source, in base ticks
  function automatic int unsigned src_period(input src_id_t id,
                                             input int unsigned stages,
                                             input int unsigned tap,
                                             input int unsigned odd);
    int unsigned p;
    case (id)
      4'd0:    p = 32'd1 << stages;
      4'd1:    p = (32'd1 << tap) * odd;
      4'd7:    p = 32'd1;
      4'd8:    p = 32'd2;
      default: p = 32'd1 << (stages + 32'd1 - 32'(id));
    endcase
    return p;
  endfunction

endpackage

// File: rtl/bd_half_stage.sv
module bd_half_stage (
  input  logic clk,
  input  logic rst,
  input  logic en_in,
  output logic en_out
);
  logic q;

  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (en_in) q <= ~q;
  end

  // Passes every second input pulse on: the one that returns q to zero
  assign en_out = en_in & q;
endmodule

// File: rtl/bd_div_odd.sv
module bd_div_odd #(
  parameter int unsigned DIV = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic en_in,
  output logic en_out
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt;
  logic         last;

  assign last = (cnt == W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (en_in) cnt <= last ? '0 : cnt + 1'b1;
  end

  assign en_out = en_in & last;
endmodule

// File: rtl/bd_src_switch.sv
module bd_src_switch
  import baud_pkg::*;
#(
  parameter int unsigned NSRC = NUM_SRC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_pulse,
  input  src_id_t         req_id,
  output src_id_t         act_id,
  output logic            pass_en
);
  src_id_t act_q;
  logic    req_hit;
  logic    pending;

  assign req_hit = src_pulse[req_id];
  assign pending = (act_q != req_id);

  // Adoption happens on a pulse of the requested source; that pulse is swallowed
  always_ff @(posedge clk) begin
    if (rst)                     act_q <= req_id;
    else if (pending && req_hit) act_q <= req_id;
  end

  assign pass_en = req_hit & ~pending;
  assign act_id  = act_q;
endmodule

// File: rtl/bd_os_count.sv
module bd_os_count #(
  parameter int unsigned RATIO = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic os_q,
  output logic bit_q
);
  localparam int unsigned W = (RATIO > 1) ? $clog2(RATIO) : 1;

  logic [W-1:0] cnt;
  logic         wrap;

  assign wrap = (cnt == W'(RATIO - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      os_q  <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      os_q  <= en;
      bit_q <= en & wrap;
      if (en) cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/baud_clock_divider.sv
module baud_clock_divider
  import baud_pkg::*;
#(
  parameter int unsigned N_STAGES   = 7,
  parameter int unsigned ODD_TAP    = 3,
  parameter int unsigned ODD_DIV    = 11,
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       base_tick,
  input  logic [2:0] rate_sel,
  input  logic       half_top,
  output logic       os_tick,
  output logic       bit_tick,
  output logic       ref_tick
);
  localparam int unsigned NSRC = NUM_SRC;

  logic [N_STAGES:0] stage_en;
  logic              odd_en;
  logic [NSRC-1:0]   src_pulse;
  src_id_t           req_id;
  src_id_t           act_id;
  logic              sel_pass;
  logic              ref_q;

  assign stage_en[0] = base_tick;

  // Binary divide chain
  for (genvar g = 1; g <= N_STAGES; g++) begin : g_stage
    bd_half_stage u_stage (
      .clk    (clk),
      .rst    (rst),
      .en_in  (stage_en[g-1]),
      .en_out (stage_en[g])
    );
  end

  // Odd branch for the 110 baud position
  bd_div_odd #(.DIV(ODD_DIV)) u_odd (
    .clk    (clk),
    .rst    (rst),
    .en_in  (stage_en[ODD_TAP]),
    .en_out (odd_en)
  );

  // Candidate sources in source-number order
  assign src_pulse[0] = stage_en[N_STAGES];
  assign src_pulse[1] = odd_en;
  for (genvar i = 2; i <= 6; i++) begin : g_tap
    assign src_pulse[i] = stage_en[N_STAGES + 1 - i];
  end
  assign src_pulse[7] = stage_en[0];
  assign src_pulse[8] = stage_en[1];

  assign req_id = req_src(rate_sel, half_top);

  bd_src_switch #(.NSRC(NSRC)) u_switch (
    .clk       (clk),
    .rst       (rst),
    .src_pulse (src_pulse),
    .req_id    (req_id),
    .act_id    (act_id),
    .pass_en   (sel_pass)
  );

  bd_os_count #(.RATIO(OVERSAMPLE)) u_os (
    .clk   (clk),
    .rst   (rst),
    .en    (sel_pass),
    .os_q  (os_tick),
    .bit_q (bit_tick)
  );

  always_ff @(posedge clk) begin
    if (rst) ref_q <= 1'b0;
    else     ref_q <= stage_en[N_STAGES];
  end

  assign ref_tick = ref_q;
endmodule

// File: rtl/baud_clock_divider_chk.sv
module baud_clock_divider_chk
  import baud_pkg::*;
#(
  parameter int unsigned N_STAGES   = 7,
  parameter int unsigned ODD_TAP    = 3,
  parameter int unsigned ODD_DIV    = 11,
  parameter int unsigned OVERSAMPLE = 16
) (
  input logic    clk,
  input logic    rst,
  input logic    base_tick,
  input logic    os_tick,
  input logic    bit_tick,
  input logic    ref_tick,
  input src_id_t act_id
);
  int unsigned gap_cnt;
  int unsigned ref_cnt;
  int unsigned os_seen;

  // Base ticks since the last output pulse, the current one included
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= 0;
      ref_cnt <= 0;
      os_seen <= 0;
    end else begin
      if (os_tick)        gap_cnt <= base_tick ? 1 : 0;
      else if (base_tick) gap_cnt <= gap_cnt + 1;
      if (ref_tick)       ref_cnt <= base_tick ? 1 : 0;
      else if (base_tick) ref_cnt <= ref_cnt + 1;
      if (bit_tick)       os_seen <= 0;
      else if (os_tick)   os_seen <= os_seen + 1;
    end
  end

  p_ref_period_r2: assert property (@(posedge clk) disable iff (rst)
    ref_tick |-> (ref_cnt == (32'd1 << N_STAGES)));

  p_min_gap_r7: assert property (@(posedge clk) disable iff (rst)
    os_tick |-> (gap_cnt >= src_period(act_id, N_STAGES, ODD_TAP, ODD_DIV)));

  p_bit_ratio_r8: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> (os_seen == OVERSAMPLE - 1));

  p_bit_with_os_r8: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> os_tick);

  p_os_after_tick_r9: assert property (@(posedge clk) disable iff (rst)
    os_tick |-> $past(base_tick));

  p_ref_after_tick_r9: assert property (@(posedge clk) disable iff (rst)
    ref_tick |-> $past(base_tick));

  p_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    (os_tick && !base_tick) |=> !os_tick);
endmodule

bind baud_clock_divider baud_clock_divider_chk #(
  .N_STAGES   (N_STAGES),
  .ODD_TAP    (ODD_TAP),
  .ODD_DIV    (ODD_DIV),
  .OVERSAMPLE (OVERSAMPLE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .base_tick (base_tick),
  .os_tick   (os_tick),
  .bit_tick  (bit_tick),
  .ref_tick  (ref_tick),
  .act_id    (act_id)
);

// File: tb/baud_clock_divider_tb.sv
module baud_clock_divider_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       base_tick = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic       half_top = 1'b0;
  logic       os_tick, bit_tick, ref_tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model state
  int unsigned nb = 0;
  int act = 0;
  int ocnt = 0;
  logic e_os, e_bit, e_ref;
  string tag_os, tag_force;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_clock_divider u_dut (
    .clk       (clk),
    .rst       (rst),
    .base_tick (base_tick),
    .rate_sel  (rate_sel),
    .half_top  (half_top),
    .os_tick   (os_tick),
    .bit_tick  (bit_tick),
    .ref_tick  (ref_tick)
  );

  // Source number requested by selector and strap
  function automatic int want(input logic [2:0] s, input logic st);
    if (s == 3'd7) return st ? 8 : 7;
    return int'(s);
  endfunction

  // Spacing in base ticks, restated from R3/R4/R5
  function automatic int unsigned spacing(input int id);
    case (id)
      0: return 128;
      1: return 8 * 11;
      2: return 64;
      3: return 32;
      4: return 16;
      5: return 8;
      6: return 4;
      7: return 1;
      default: return 2;
    endcase
  endfunction

  task automatic model(input logic bt, input logic [2:0] s, input logic st, input logic r);
    int rq;
    logic hit;
    e_os = 1'b0; e_bit = 1'b0; e_ref = 1'b0;
    rq = want(s, st);
    if (r) begin
      nb = 0; act = rq; ocnt = 0; tag_os = "R1";
    end else if (!bt) begin
      tag_os = "R10";
    end else begin
      nb++;
      hit = (nb % spacing(rq)) == 0;
      e_ref = (nb % 128) == 0;
      if (act != rq) begin
        tag_os = "R7";
        if (hit) act = rq;
      end else begin
        tag_os = (rq == 1) ? "R4" : (rq >= 7) ? "R5" : "R3";
        if (hit) begin
          e_os = 1'b1;
          e_bit = (ocnt == 15);
          ocnt = (ocnt + 1) % 16;
        end
      end
    end
    if (tag_force != "") tag_os = tag_force;
  endtask

  task automatic check1(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b expected %0b (base tick %0d)", req, what, got, exp, nb);
    end
  endtask

  // Drive at the falling edge, sample a quarter period after the rising edge (R9 latency)
  task automatic cyc(input logic bt, input logic [2:0] s, input logic st, input logic r);
    base_tick = bt; rate_sel = s; half_top = st; rst = r;
    model(bt, s, st, r);
    @(posedge clk);
    #(CLK_PERIOD/4);
    check1(tag_os, "os_tick", os_tick, e_os);
    check1(r ? "R1" : "R8", "bit_tick", bit_tick, e_bit);
    check1(r ? "R1" : "R2", "ref_tick", ref_tick, e_ref);
    @(negedge clk);
  endtask

  task automatic run(input int n, input logic [2:0] s, input logic st, input int dens);
    for (int i = 0; i < n; i++) begin
      logic bt;
      bt = (dens == 0) ? 1'b1 : (($urandom % dens) != 0);
      cyc(bt, s, st, 1'b0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    tag_force = "";
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 4; i++) cyc(1'b1, 3'd2, 1'b0, 1'b1);
    // R9: alternating ticks at the base-rate position
    tag_force = "R9";
    for (int i = 0; i < 8; i++) cyc(i[0] == 1'b0, 3'd7, 1'b0, 1'b0);
    tag_force = "";
    // R2/R3: slowest source, dense ticks
    run(300, 3'd0, 1'b0, 0);
    // R4: odd branch
    run(400, 3'd1, 1'b0, 0);
    // R5: strap set at the top position
    run(60, 3'd7, 1'b1, 0);
    run(60, 3'd7, 1'b0, 3);
    // R6: strap toggling while selector is 4
    tag_force = "R6";
    for (int i = 0; i < 80; i++) run(5, 3'd4, i[0], 0);
    tag_force = "";
    // R10: idle base tick, then resume
    run(50, 3'd5, 1'b0, 1);
    for (int i = 0; i < 50; i++) cyc(1'b0, 3'd5, 1'b0, 1'b0);
    run(50, 3'd5, 1'b0, 0);
    // R7: switching slow to fast and back
    run(70, 3'd0, 1'b0, 0);
    run(200, 3'd5, 1'b0, 0);
    run(300, 3'd0, 1'b0, 0);
    // R1: mid-run reset with a new selection
    for (int i = 0; i < 3; i++) cyc(1'b1, 3'd6, 1'b1, 1'b1);
    run(100, 3'd6, 1'b1, 0);
    // Random segments
    for (int seg = 0; seg < 40; seg++) begin
      logic [2:0] s;
      logic st;
      int len, dens;
      s = 3'($urandom % 8);
      st = 1'($urandom % 2);
      len = 100 + int'($urandom % 2500);
      dens = int'($urandom % 4);
      run(len, s, st, dens);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule